// File: doc/BRIEF.md
# Timer Channel Interrupt Requester

This block is the interrupt front end of a sixteen-channel timer peripheral. Each timer channel has a pending flag that its time function sets with a one-cycle event pulse, and a software enable bit. Whenever at least one enabled channel is pending, the block asserts exactly one line of a seven-line prioritized request bus. Software chooses the line through a programmable level.

The CPU acknowledges a request by presenting the acknowledged priority level. If that level equals the block's own level, the block joins a bus-wide serial arbitration using its 4-bit arbitration number. The arbitration line is wired-OR, and the number is resolved MSB first at one bit per cycle. If the block wins, it presents an 8-bit vector for one cycle. The upper nibble of the vector is a programmable base and the lower nibble is the number of the highest pending enabled channel.

Top module: `timer_irq_front`

## Requirements
- R1: The channel enable mask sits at register address 0, with bit i enabling channel i. It is readable and writable and resets to 0.
- R2: A one-cycle pulse on chanEvent[i] sets pending flag i, which is readable at address 1. Writing ones to address 1 never sets a flag.
- R3: Configuration register address 2 holds three fields: bits [2:0] are the request level, bits [7:4] are the vector base and bits [11:8] are the arbitration number. All three reset to 0.
- R4: irqOut bit k stands for request line k+1. When an enabled flag is set and the level L is nonzero, bit L-1 is high from the second clock edge after the event onward. No other bit is high.
- R5: With level 0, irqOut stays all zero whatever flags are set.
- R6: irqOut returns to zero on the clock edge after the one at which the last enabled pending flag clears.
- R7: A flag clears only when software first reads address 1 while that flag is set and then writes 0 to that bit. A write of 0 without the prior read leaves the flag set. An event in the same cycle as the clearing write leaves the flag set.
- R8: The block enters arbitration only on a cycle with ackValid high and ackLevel equal to its nonzero level, a nonzero arbitration number and an enabled pending flag. Otherwise arbDrive and vecValid stay low.
- R9: Arbitration takes the four cycles after the entry edge, bit 3 first. In each cycle arbDrive carries the current bit. The block drops out when its bit is 0 but arbLineIn is 1.
- R10: After winning all four bits, vecValid is high for exactly one cycle. vecData then equals {base, c}, where c is the highest-numbered enabled pending channel at entry.
- R11: With arbitration number 0 the block never drives arbDrive or vecValid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | 2 | Register address |
| regWrData | input | 16 | Write data |
| regRdData | output | 16 | Read data for regAddr |
| chanEvent | input | 16 | One-cycle event pulses from the time functions |
| irqOut | output | 7 | Request bus, bit k is line k+1 |
| ackValid | input | 1 | Acknowledge cycle start |
| ackLevel | input | 3 | Acknowledged priority level |
| arbLineIn | input | 1 | Observed wired-OR arbitration line |
| arbDrive | output | 1 | This block's arbitration bit |
| vecValid | output | 1 | Vector present |
| vecData | output | 8 | Interrupt vector |

## Verification
The bench pits the block against a competing arbiter whose numbers cause it to win at a middle bit, lose at the first bit, and face no rival at all. A design that compared bits in the wrong order or ignored the line would then return a vector when it should stay silent. It also drives an event in the same cycle as the clearing write and a write of 0 without a prior read. A flag lost in either case would show up as a missing request. Further tests acknowledge a level that does not match, use a zero arbitration number, and time the request drop to the exact edge, so that an extra or missing register stage is caught.

// File: rtl/irq_front_pkg.sv
package irq_front_pkg;
  typedef struct packed {
    logic       startArb;
    logic       busy;
    logic [1:0] bitSel;
    logic       showVec;
  } ctrlStrobe_t;
endpackage

// File: rtl/irq_front_ctrl.sv
module irq_front_ctrl
  import irq_front_pkg::*;
#(
  parameter int LEVEL_W = 3,
  parameter int ARB_W   = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               ackValid,
  input  logic [LEVEL_W-1:0] ackLevel,
  input  logic [LEVEL_W-1:0] cfgLevel,
  input  logic [ARB_W-1:0]   cfgArb,
  input  logic               pending,
  input  logic               arbLineIn,
  output ctrlStrobe_t        strobe
);
  typedef enum logic [1:0] {ST_IDLE, ST_ARB, ST_WIN} arbState_t;
  arbState_t state;
  logic [1:0] bitIdx;

  always_comb begin
    strobe.startArb = (state == ST_IDLE) && ackValid && (ackLevel == cfgLevel)
                      && (cfgLevel != '0) && (cfgArb != '0) && pending;
    strobe.busy    = (state == ST_ARB);
    strobe.bitSel  = bitIdx;
    strobe.showVec = (state == ST_WIN);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitIdx <= '0;
    end else begin
      case (state)
        ST_IDLE: if (strobe.startArb) begin
          state  <= ST_ARB;
          bitIdx <= 2'(ARB_W - 1);
        end
        ST_ARB: begin
          if (!cfgArb[bitIdx] && arbLineIn) state <= ST_IDLE;
          else if (bitIdx == '0)            state <= ST_WIN;
          else                              bitIdx <= bitIdx - 2'd1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/irq_front_dp.sv
module irq_front_dp
  import irq_front_pkg::*;
#(
  parameter int CHANNELS = 16,
  parameter int LEVEL_W  = 3,
  parameter int ARB_W    = 4,
  parameter int VEC_W    = 8,
  localparam int CH_W    = $clog2(CHANNELS),
  localparam int BASE_W  = VEC_W - CH_W,
  localparam int IRQ_W   = (1 << LEVEL_W) - 1,
  localparam int BASE_LSB = 4,
  localparam int ARB_LSB  = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic                regRdEn,
  input  logic [1:0]          regAddr,
  input  logic [CHANNELS-1:0] regWrData,
  output logic [CHANNELS-1:0] regRdData,
  input  logic [CHANNELS-1:0] chanEvent,
  input  ctrlStrobe_t         strobe,
  output logic [IRQ_W-1:0]    irqOut,
  output logic                arbDrive,
  output logic                vecValid,
  output logic [VEC_W-1:0]    vecData,
  output logic [LEVEL_W-1:0]  cfgLevel,
  output logic [ARB_W-1:0]    cfgArb,
  output logic [CHANNELS-1:0] statusFlags,
  output logic                pending
);
  logic [CHANNELS-1:0] enMask, readArm, clrMask, active;
  logic [BASE_W-1:0]   cfgBase;
  logic [CH_W-1:0]     hiChan, chanLatch;

  assign active  = statusFlags & enMask;
  assign pending = |active;
  assign clrMask = (regWrEn && regAddr == 2'd1) ? (readArm & ~regWrData) : '0;

  always_comb begin
    hiChan = '0;
    for (int i = 0; i < CHANNELS; i++)
      if (active[i]) hiChan = CH_W'(i);
  end

  always_comb begin
    regRdData = '0;
    case (regAddr)
      2'd0: regRdData = enMask;
      2'd1: regRdData = statusFlags;
      2'd2: begin
        regRdData[LEVEL_W-1:0]               = cfgLevel;
        regRdData[BASE_LSB +: BASE_W]        = cfgBase;
        regRdData[ARB_LSB +: ARB_W]          = cfgArb;
      end
      default: regRdData = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enMask <= '0; statusFlags <= '0; readArm <= '0;
      cfgLevel <= '0; cfgBase <= '0; cfgArb <= '0;
      irqOut <= '0; chanLatch <= '0;
    end else begin
      statusFlags <= (statusFlags & ~clrMask) | chanEvent;
      if (regRdEn && regAddr == 2'd1)      readArm <= statusFlags;
      else if (regWrEn && regAddr == 2'd1) readArm <= '0;
      if (regWrEn && regAddr == 2'd0) enMask <= regWrData;
      if (regWrEn && regAddr == 2'd2) begin
        cfgLevel <= regWrData[LEVEL_W-1:0];
        cfgBase  <= regWrData[BASE_LSB +: BASE_W];
        cfgArb   <= regWrData[ARB_LSB +: ARB_W];
      end
      if (pending && cfgLevel != '0)
        irqOut <= IRQ_W'(1) << (cfgLevel - LEVEL_W'(1));
      else
        irqOut <= '0;
      if (strobe.startArb) chanLatch <= hiChan;
    end
  end

  assign arbDrive = strobe.busy && cfgArb[strobe.bitSel];
  assign vecValid = strobe.showVec;
  assign vecData  = strobe.showVec ? {cfgBase, chanLatch} : '0;
endmodule

// File: rtl/timer_irq_front.sv
module timer_irq_front
  import irq_front_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic        regRdEn,
  input  logic [1:0]  regAddr,
  input  logic [15:0] regWrData,
  output logic [15:0] regRdData,
  input  logic [15:0] chanEvent,
  output logic [6:0]  irqOut,
  input  logic        ackValid,
  input  logic [2:0]  ackLevel,
  input  logic        arbLineIn,
  output logic        arbDrive,
  output logic        vecValid,
  output logic [7:0]  vecData
);
  ctrlStrobe_t strobe;
  logic [2:0]  cfgLevel;
  logic [3:0]  cfgArb;
  logic [15:0] statusFlags;
  logic        pending;

  irq_front_ctrl #(.LEVEL_W(3), .ARB_W(4)) ctrl (
    .clk(clk), .rstN(rstN), .ackValid(ackValid), .ackLevel(ackLevel),
    .cfgLevel(cfgLevel), .cfgArb(cfgArb), .pending(pending),
    .arbLineIn(arbLineIn), .strobe(strobe)
  );

  irq_front_dp #(.CHANNELS(16), .LEVEL_W(3), .ARB_W(4), .VEC_W(8)) dp (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .chanEvent(chanEvent), .strobe(strobe), .irqOut(irqOut),
    .arbDrive(arbDrive), .vecValid(vecValid), .vecData(vecData),
    .cfgLevel(cfgLevel), .cfgArb(cfgArb), .statusFlags(statusFlags),
    .pending(pending)
  );
endmodule

// File: rtl/irq_front_chk.sv
module irq_front_chk (
  input logic        clk,
  input logic        rstN,
  input logic [6:0]  irqOut,
  input logic [2:0]  cfgLevel,
  input logic [3:0]  cfgArb,
  input logic [15:0] chanEvent,
  input logic [15:0] statusFlags,
  input logic        arbDrive,
  input logic        vecValid
);
  assert_irq_onehot_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(irqOut));

  assert_level_zero_quiet_R5: assert property (@(posedge clk) disable iff (!rstN)
    (cfgLevel == 3'd0) |=> (irqOut == 7'd0));

  assert_event_sets_flag_R2: assert property (@(posedge clk) disable iff (!rstN)
    (chanEvent != 16'd0) |=> ((statusFlags & $past(chanEvent)) == $past(chanEvent)));

  assert_vec_single_cycle_R10: assert property (@(posedge clk) disable iff (!rstN)
    vecValid |=> !vecValid);

  assert_zero_arb_silent_R11: assert property (@(posedge clk) disable iff (!rstN)
    (cfgArb == 4'd0) |-> (!arbDrive && !vecValid));
endmodule

bind timer_irq_front irq_front_chk chk (
  .clk(clk), .rstN(rstN), .irqOut(irqOut), .cfgLevel(cfgLevel),
  .cfgArb(cfgArb), .chanEvent(chanEvent), .statusFlags(statusFlags),
  .arbDrive(arbDrive), .vecValid(vecValid)
);

// File: tb/tb_timer_irq_front.sv
module tb_timer_irq_front;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0, regRdEn = 1'b0;
  logic [1:0]  regAddr = '0;
  logic [15:0] regWrData = '0, regRdData;
  logic [15:0] chanEvent = '0;
  logic [6:0]  irqOut;
  logic        ackValid = 1'b0;
  logic [2:0]  ackLevel = '0;
  logic        arbLineIn = 1'b0;
  logic        arbDrive, vecValid;
  logic [7:0]  vecData;
  int checks = 0, errors = 0;
  logic [15:0] rd;

  always #2 clk = ~clk;

  timer_irq_front dut (.*);

  // level, enable, events, expIrq, expVec, competitor, expWin
  localparam logic [54:0] VEC_TBL [0:4] = '{
    {3'd5, 16'hFFFF, 16'h0001, 7'b0010000, 8'hA0, 4'h0, 1'b1},
    {3'd7, 16'h00F0, 16'h0081, 7'b1000000, 8'hA7, 4'h3, 1'b1},
    {3'd1, 16'hFFFF, 16'h8004, 7'b0000001, 8'hAF, 4'h9, 1'b0},
    {3'd3, 16'h0F00, 16'h0300, 7'b0000100, 8'hA9, 4'h5, 1'b1},
    {3'd2, 16'h0001, 16'h0002, 7'b0000000, 8'h00, 4'h0, 1'b0}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(negedge clk); regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(posedge clk); #1 regWrEn = 1'b0;
  endtask

  task automatic rdReg(logic [1:0] a, output logic [15:0] d);
    @(negedge clk); regAddr = a; regRdEn = 1'b1; d = regRdData;
    @(posedge clk); #1 regRdEn = 1'b0;
  endtask

  task automatic pulse(logic [15:0] ev);
    @(negedge clk); chanEvent = ev;
    @(posedge clk); #1 chanEvent = '0;
  endtask

  task automatic clearAll();
    logic [15:0] d;
    rdReg(2'd1, d);
    wr(2'd1, 16'h0000);
  endtask

  // acknowledge then run four arbitration bits against a competitor
  task automatic arbitrate(logic [2:0] lvl, logic [3:0] comp, output logic won,
                           output logic [7:0] vec, output logic anyDrive);
    logic compIn, line;
    compIn = (comp != 4'd0);
    anyDrive = 1'b0;
    @(negedge clk); ackValid = 1'b1; ackLevel = lvl;
    @(posedge clk); #1 ackValid = 1'b0;
    for (int i = 3; i >= 0; i--) begin
      @(negedge clk);
      anyDrive = anyDrive | arbDrive;
      line = arbDrive | (compIn & comp[i]);
      arbLineIn = line;
      if (!comp[i] && line) compIn = 1'b0;
      @(posedge clk); #1;
    end
    arbLineIn = 1'b0;
    @(negedge clk);
    won = vecValid; vec = vecData;
    tick();
  endtask

  initial begin
    logic won, drv;
    logic [7:0] vec;
    tick(); tick();
    rstN = 1'b1;
    @(negedge clk);
    // reset state
    regAddr = 2'd0; #0 check("R1 enable reset", regRdData, 0);
    regAddr = 2'd1; #0 check("R2 flags reset", regRdData, 0);
    regAddr = 2'd2; #0 check("R3 config reset", regRdData, 0);
    check("R4 irq reset", irqOut, 0);

    // level 0: no request; zero arbitration number: silent
    wr(2'd0, 16'hFFFF);
    rdReg(2'd0, rd); check("R1 enable readback", rd, 16'hFFFF);
    pulse(16'h0010); tick();
    @(negedge clk); check("R5 level zero no request", irqOut, 0);
    wr(2'd2, 16'h00A5);
    arbitrate(3'd5, 4'h0, won, vec, drv);
    check("R11 zero arb no drive", drv, 0);
    check("R11 zero arb no vector", won, 0);
    clearAll();

    wr(2'd2, 16'h06A5);
    rdReg(2'd2, rd); check("R3 config fields", rd, 16'h06A5);

    // table walk
    for (int k = 0; k < 5; k++) begin
      logic [54:0] v;
      v = VEC_TBL[k];
      wr(2'd2, 16'h06A0 | 16'(v[54:52]));
      wr(2'd0, v[51:36]);
      pulse(v[35:20]);
      tick();
      @(negedge clk);
      check("R4 request line", irqOut, v[19:13]);
      arbitrate(v[54:52], v[4:1], won, vec, drv);
      check("R9 arbitration outcome", won, v[0]);
      if (v[0]) check("R10 vector value", vec, v[12:5]);
      if (v[51:36] == 16'h0001) check("R8 no pending no drive", drv, 0);
      clearAll(); tick();
    end

    // wrong acknowledged level
    wr(2'd2, 16'h06A4); wr(2'd0, 16'hFFFF);
    pulse(16'h0040);
    arbitrate(3'd3, 4'h0, won, vec, drv);
    check("R8 mismatched level no drive", drv, 0);
    check("R8 mismatched level no vector", won, 0);
    clearAll(); tick();

    // writing ones does not set
    wr(2'd1, 16'hFFFF);
    rdReg(2'd1, rd); check("R2 write ones ignored", rd, 0);

    // clear without prior read ignored; exact deassert timing
    pulse(16'h0008);
    wr(2'd1, 16'h0000);
    rdReg(2'd1, rd); check("R7 clear needs read", rd, 16'h0008);
    @(negedge clk); regAddr = 2'd1; regWrData = 16'h0000; regWrEn = 1'b1;
    @(posedge clk); #1 regWrEn = 1'b0;
    @(negedge clk); check("R6 request held one more cycle", irqOut, 7'b0001000);
    tick();
    @(negedge clk); check("R6 request dropped", irqOut, 0);
    rdReg(2'd1, rd); check("R7 flag cleared", rd, 0);

    // event racing the clearing write
    pulse(16'h0020);
    rdReg(2'd1, rd);
    @(negedge clk); regAddr = 2'd1; regWrData = 16'h0000; regWrEn = 1'b1; chanEvent = 16'h0020;
    @(posedge clk); #1 regWrEn = 1'b0; chanEvent = '0;
    rdReg(2'd1, rd); check("R7 event wins over clear", rd, 16'h0020);
    tick();
    @(negedge clk); check("R4 request kept after race", irqOut, 7'b0001000);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule